// File: doc/BRIEF.md
# Iterative Radix-4 Booth Carry-Save Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits (32 by default) and returns the full signed product of `2*WIDTH` bits. A request is accepted on a clock edge where `start` is high and the unit is idle. The operands are captured on that edge. The product then takes three more clock cycles.

In each of the first two work cycles, half of the multiplier is recoded into radix-4 Booth digits. Each digit is one of {-2, -1, 0, +1, +2} and scales the multiplicand. The resulting partial products are merged with the sum and carry vectors held from the previous cycle in a chain of 3:2 carry-save adders. A narrow adder of half the operand width then resolves the next group of low product bits. The carry out of that adder feeds the next low group. In the third cycle a carry-propagate adder of operand width resolves the upper half of the product. `done` pulses for one cycle when the product is ready.

Top module: `booth_csa_mul`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, `busy` and `done` are 0.
- R2: When `done` is 1, `product` equals the signed 64-bit product of the `a_in` and `b_in` values captured on the accepting edge.
- R3: `done` is 1 for exactly one cycle. It rises on the third clock edge after the edge that accepted `start`.
- R4: `busy` is 1 from the accepting edge up to the edge on which `done` rises. It is 0 at all other times.
- R5: A `start` seen while `busy` is 1 has no effect. Operand changes during an operation do not alter its product, and no extra `done` pulse follows.
- R6: The product is exact for corner operands: -2^31, -1, 0, 1 and 2^31-1, in every pairing.
- R7: A `start` in the cycle where `done` is 1 is accepted at once, so operations can follow with no idle cycle.
- R8: The multiplier is recoded in overlapping 3-bit groups. Groups 000 and 111 select 0, 001 and 010 select +A, 011 selects +2A, 100 selects -2A, and 101 and 110 select -A. The lowest group of the upper multiplier half takes multiplier bit 15 as its low bit, and the lowest group of the lower half takes 0. The product is exact for patterns that hit every group value and both values of bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; taken only when idle |
| a_in | input | 32 | Multiplicand, signed |
| b_in | input | 32 | Multiplier, signed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `product` is valid |
| product | output | 64 | Signed product |

## Verification
Random signed operand pairs check the carry-save loop and the split low addition over general data. The corner pairs built from the most negative value, -1, 0, 1 and the largest positive value catch errors in sign extension and in the complement-plus-one injection. Fixed multiplier patterns (alternating bits, runs of ones, a lone bit 15, halves of all ones) select each digit value. They also separate a correct overlap bit between the two multiplier halves from a dropped one. Requests held high during an operation, and requests issued in the `done` cycle, show whether starts are ignored while busy and whether back-to-back issue works.

// File: rtl/booth_csa_mul.sv
module booth_csa_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   a_in,
  input  logic [WIDTH-1:0]   b_in,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int HALF   = WIDTH / 2;
  localparam int DIGITS = HALF / 2;
  localparam int PW     = 2 * WIDTH;
  localparam int OPS    = DIGITS + 3;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_MID, S_HI} st_t;
  st_t st;

  logic [WIDTH-1:0] a_q, b_q;
  logic [PW-1:0]    s_q, c_q;
  logic             cy_q;

  wire second = (st == S_MID);
  wire [HALF:0]   grp_bits = second ? {b_q[WIDTH-1:HALF], b_q[HALF-1]} : {b_q[HALF-1:0], 1'b0};
  wire [PW-1:0]   m1 = {{WIDTH{a_q[WIDTH-1]}}, a_q};
  wire [PW-1:0]   m2 = {m1[PW-2:0], 1'b0};

  logic [PW-1:0] opnd [OPS];
  logic [PW-1:0] nv   [DIGITS];
  logic [PW-1:0] negv;

  for (genvar j = 0; j < DIGITS; j++) begin : g_digit
    wire [2:0]    g    = grp_bits[2*j+2:2*j];
    wire          neg  = g[2] & ~(g[1] & g[0]);
    wire          two  = (g == 3'b011) | (g == 3'b100);
    wire          zero = (g == 3'b000) | (g == 3'b111);
    wire [PW-1:0] mag  = zero ? '0 : (two ? m2 : m1);
    wire [PW-1:0] sel  = neg ? ~mag : mag;
    wire [PW-1:0] one  = {{(PW-1){1'b0}}, neg};
    assign opnd[j+3] = second ? (sel << (HALF + 2*j)) : (sel << (2*j));
    assign nv[j]     = second ? (one << (HALF + 2*j)) : (one << (2*j));
  end

  always_comb begin
    negv = '0;
    for (int j = 0; j < DIGITS; j++) negv = negv | nv[j];
  end

  assign opnd[0] = s_q;
  assign opnd[1] = c_q;
  assign opnd[2] = negv;

  logic [PW-1:0] ps [OPS-1];
  logic [PW-1:0] pc [OPS-1];
  assign ps[0] = opnd[0];
  assign pc[0] = opnd[1];

  for (genvar i = 0; i < OPS-2; i++) begin : g_csa
    wire [PW-1:0] x = ps[i];
    wire [PW-1:0] y = pc[i];
    wire [PW-1:0] z = opnd[i+2];
    wire [PW-1:0] maj = (x & y) | (x & z) | (y & z);
    assign ps[i+1] = x ^ y ^ z;
    assign pc[i+1] = {maj[PW-2:0], 1'b0};
  end

  wire [PW-1:0]   fs   = ps[OPS-2];
  wire [PW-1:0]   fc   = pc[OPS-2];
  wire [HALF-1:0] lo_s = second ? fs[WIDTH-1:HALF] : fs[HALF-1:0];
  wire [HALF-1:0] lo_c = second ? fc[WIDTH-1:HALF] : fc[HALF-1:0];
  wire [HALF:0]   lo   = {1'b0, lo_s} + {1'b0, lo_c} + {{HALF{1'b0}}, cy_q};
  wire [PW-1:0]   keep = second ? {{(PW-WIDTH){1'b1}}, {WIDTH{1'b0}}}
                                : {{(PW-HALF){1'b1}}, {HALF{1'b0}}};
  wire [WIDTH-1:0] hi  = s_q[PW-1:WIDTH] + c_q[PW-1:WIDTH] + {{(WIDTH-1){1'b0}}, cy_q};

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      s_q     <= '0;
      c_q     <= '0;
      cy_q    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          a_q  <= a_in;
          b_q  <= b_in;
          s_q  <= '0;
          c_q  <= '0;
          cy_q <= 1'b0;
          st   <= S_LO;
        end
        S_LO, S_MID: begin
          s_q  <= fs & keep;
          c_q  <= fc & keep;
          cy_q <= lo[HALF];
          if (second) begin
            product[WIDTH-1:HALF] <= lo[HALF-1:0];
            st <= S_HI;
          end else begin
            product[HALF-1:0] <= lo[HALF-1:0];
            st <= S_MID;
          end
        end
        default: begin
          product[PW-1:WIDTH] <= hi;
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module booth_csa_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   a_in,
  input logic [WIDTH-1:0]   b_in,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;
  logic [1:0]    age;
  logic          due;
  logic          was_rst;
  logic [PW-1:0] ref_p;

  always_ff @(posedge clk) begin
    was_rst <= !rst_n;
    if (!rst_n) begin
      age   <= '0;
      due   <= 1'b0;
      ref_p <= '0;
    end else begin
      due <= (age == 2'd3);
      if (age != 2'd0) age <= age + 2'd1;
      else if (start) begin
        age   <= 2'd1;
        ref_p <= {{WIDTH{a_in[WIDTH-1]}}, a_in} * {{WIDTH{b_in[WIDTH-1]}}, b_in};
      end
    end
  end

  always @(posedge clk)
    if (was_rst === 1'b1) a_reset_idle_r1: assert (!busy && !done);

  p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == ref_p);
  p_done_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done == due);
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (age != 2'd0));
endmodule

bind booth_csa_mul booth_csa_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
  .busy(busy), .done(done), .product(product)
);

// File: tb/tb_booth_csa_mul.sv
module tb_booth_csa_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic        busy, done;
  logic [63:0] product;

  booth_csa_mul dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .product(product)
  );

  always #5 clk = ~clk;

  int          nchk = 0, nfail = 0, cyc = 0;
  int          pend = 0;
  logic        exp_done = 1'b0;
  logic [63:0] expv = '0;
  string       tag = "R2";
  bit          finished = 0;

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pend = 0;
      exp_done = 1'b0;
    end else begin
      exp_done = (pend == 1);
      if (pend > 0) pend--;
      else if (start) begin
        pend = 3;
        expv = 64'(longint'($signed(a_in)) * longint'($signed(b_in)));
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R3 done", {63'd0, done}, {63'd0, exp_done});
    chk("R4 busy", {63'd0, busy}, {63'd0, pend != 0});
    if (exp_done) chk({"R2 product ", tag}, product, expv);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nfail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input int gap);
    @(negedge clk);
    start = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0; a_in = $urandom; b_in = $urandom;
    repeat (gap - 1) @(negedge clk);
  endtask

  initial begin
    logic [31:0] corners [5];
    logic [31:0] pats [10];
    corners = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h7FFF_FFFF};
    pats = '{32'h5555_5555, 32'hAAAA_AAAA, 32'h0000_8000, 32'h0000_FFFF,
             32'hFFFF_0000, 32'h3333_3333, 32'hCCCC_CCCC, 32'h0001_8000,
             32'h7FFF_8000, 32'h8000_7FFF};
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    chk("R1 reset done", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle busy", {63'd0, busy}, 64'd0);
    chk("R1 idle done", {63'd0, done}, 64'd0);

    tag = "R6 corners";
    foreach (corners[i]) foreach (corners[k]) issue(corners[i], corners[k], 5);

    tag = "R8 digit patterns";
    foreach (pats[i]) begin
      issue(32'h1234_5679, pats[i], 5);
      issue(32'h8000_0000, pats[i], 5);
      issue(32'hFFFF_FFFF, pats[i], 5);
    end

    tag = "R5 start while busy";
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      start = 1'b1; a_in = $urandom; b_in = $urandom;
      for (int m = 0; m < 3; m++) begin
        @(negedge clk);
        a_in = $urandom; b_in = $urandom;
      end
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
    end

    tag = "R7 back-to-back";
    for (int n = 0; n < 40; n++) issue($urandom, $urandom, 3);
    repeat (5) @(negedge clk);

    tag = "R2 random";
    for (int n = 0; n < 400; n++) issue($urandom, $urandom, 3 + (n % 3));
    repeat (6) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule